// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by reading one entry from a flat page table in memory. A requester presents a virtual address, whether the access is a write, and whether it runs in supervisor mode, together with the base address of the current process's table. The walker splits the address into a page number and an in-page offset. It forms the entry address from the base plus four bytes per page number and issues a single read on a variable-latency memory port.

When the entry returns, the walker decodes its present flag and its three permission flags against the access. It answers with either the physical address (the entry's frame number joined to the unchanged offset) or a two-bit fault code that separates a missing page from a permission violation. Handling the fault is left to the requester. The walker holds one translation at a time and refuses new work until it has answered.

Top module: `pt_walker`

## Requirements
- R1: While reset is high and in the first cycle after it falls, req_ready is 1, mem_req_valid is 0 and resp_valid is 0.
- R2: A request is taken only on a cycle where req_valid and req_ready are both 1. req_ready is 0 from the cycle after acceptance until the walk has answered, and req_valid during that time causes no memory read and no response.
- R3: The entry address on mem_req_addr equals ptbr plus four times the page number (vaddr bits above PG_BITS), taken modulo 2^PA_BITS.
- R4: mem_req_valid stays high with an unchanged mem_req_addr until a cycle with mem_req_ready high. Each walk issues exactly one read, and mem_req_valid is low in the cycle after acceptance.
- R5: The entry is taken from the first cycle with mem_resp_valid high after the read was accepted, for any delay of zero or more cycles.
- R6: If the entry's present flag (bit PPN_W+3) is 0, resp_fault is 2'b01 and resp_paddr is 0, regardless of the permission flags.
- R7: A write to a present page whose write flag (bit PPN_W+1) is 0 gives resp_fault 2'b10 and resp_paddr 0.
- R8: A user-mode access (req_super 0) to a present page whose supervisor flag (bit PPN_W+2) is 1 gives resp_fault 2'b10. A supervisor-mode access to that page is not refused for that reason.
- R9: A read from a present page whose read flag (bit PPN_W) is 0 gives resp_fault 2'b10 and resp_paddr 0.
- R10: An access that passes every check gives resp_fault 2'b00 and resp_paddr equal to the frame number (entry bits PPN_W-1:0) concatenated with the low PG_BITS of the virtual address.
- R11: resp_valid is high for exactly one cycle per accepted request, and req_ready is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | VA_BITS | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_super | input | 1 | 1 for supervisor mode, 0 for user mode |
| ptbr | input | PA_BITS | Base address of the page table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_BITS | Byte address of the entry |
| mem_resp_valid | input | 1 | Entry word returned |
| mem_resp_data | input | WORD_BITS | Entry word |
| resp_valid | output | 1 | Translation result valid (one cycle) |
| resp_paddr | output | PA_BITS | Physical address, 0 on a fault |
| resp_fault | output | 2 | 00 ok, 01 not present, 10 permission |

## Verification
A walker that leaves its state machine in the wrong state shows it at the ports within one or two cycles. req_ready stays low and no response ever comes, or a second response appears that no request asked for. A lost issued flag shows as a second memory read or as a read request that drops before it is accepted. A captured field that is wrong or stale surfaces on the next response, either as a bad entry address seen by the memory model or as a frame, offset or fault code that differs from the value computed from the entry the bench supplied.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_PTE = 2'd1,
        ST_RESPOND  = 2'd2
    } ptw_state_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_ABSENT = 2'b01,
        FLT_PERM   = 2'b10
    } ptw_fault_e;

    typedef struct packed {
        logic present;
        logic sup;
        logic wr;
        logic rd;
    } pte_flags_t;

    typedef struct packed {
        logic is_write;
        logic is_super;
    } access_t;

    function automatic ptw_fault_e judge_access(pte_flags_t f, access_t a);
        if (!f.present)
            return FLT_ABSENT;
        if (a.is_write && !f.wr)
            return FLT_PERM;
        if (!a.is_write && !f.rd)
            return FLT_PERM;
        if (!a.is_super && f.sup)
            return FLT_PERM;
        return FLT_NONE;
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int VA_BITS = 32,
    parameter int PA_BITS = 32,
    parameter int PG_BITS = 12
) (
    input  logic [PA_BITS-1:0] base,
    input  logic [VA_BITS-1:0] vaddr,
    output logic [PA_BITS-1:0] entry_addr,
    output logic [PG_BITS-1:0] offset
);
    localparam int VPN_W = VA_BITS - PG_BITS;
    localparam int SCL_W = VPN_W + 2;
    localparam int SUM_W = (PA_BITS > SCL_W) ? PA_BITS : SCL_W;

    logic [VPN_W-1:0] vpn;
    logic [SCL_W-1:0] scaled;
    logic [SUM_W-1:0] sum;

    always_comb begin
        vpn        = vaddr[VA_BITS-1:PG_BITS];
        offset     = vaddr[PG_BITS-1:0];
        scaled     = {vpn, 2'b00};
        sum        = SUM_W'(base) + SUM_W'(scaled);
        entry_addr = sum[PA_BITS-1:0];
    end
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
#(
    parameter int PA_BITS   = 32,
    parameter int PG_BITS   = 12,
    parameter int WORD_BITS = 32
) (
    input  logic [WORD_BITS-1:0] entry,
    input  access_t              acc,
    input  logic [PG_BITS-1:0]   offset,
    output ptw_fault_e           fault,
    output logic [PA_BITS-1:0]   paddr
);
    localparam int PPN_W = PA_BITS - PG_BITS;

    logic [PPN_W-1:0] ppn;
    pte_flags_t       flags;

    always_comb begin
        ppn   = entry[PPN_W-1:0];
        flags = entry[PPN_W+3:PPN_W];
        fault = judge_access(flags, acc);
        paddr = (fault == FLT_NONE) ? {ppn, offset} : '0;
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    output logic req_ready,
    output logic req_take,
    output logic mem_req_valid,
    input  logic mem_req_ready,
    input  logic mem_resp_valid,
    output logic pte_take,
    output logic resp_valid
);
    ptw_state_e state_q;
    logic       issued_q;

    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        req_take      = req_ready && req_valid;
        mem_req_valid = (state_q == ST_WAIT_PTE) && !issued_q;
        pte_take      = (state_q == ST_WAIT_PTE) && issued_q && mem_resp_valid;
        resp_valid    = (state_q == ST_RESPOND);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            issued_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    issued_q <= 1'b0;
                    if (req_valid) state_q <= ST_WAIT_PTE;
                end
                ST_WAIT_PTE: begin
                    if (!issued_q && mem_req_ready) issued_q <= 1'b1;
                    if (pte_take) state_q <= ST_RESPOND;
                end
                ST_RESPOND: begin
                    issued_q <= 1'b0;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> (!resp_valid && req_ready)); // R11

    AST_MEMREQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid); // R4

    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_req_valid && !resp_valid)); // R2

    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        req_take |=> !req_ready); // R2
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int VA_BITS   = 32,
    parameter int PA_BITS   = 32,
    parameter int PG_BITS   = 12,
    parameter int WORD_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [VA_BITS-1:0]   req_vaddr,
    input  logic                 req_write,
    input  logic                 req_super,
    input  logic [PA_BITS-1:0]   ptbr,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [PA_BITS-1:0]   mem_req_addr,
    input  logic                 mem_resp_valid,
    input  logic [WORD_BITS-1:0] mem_resp_data,
    output logic                 resp_valid,
    output logic [PA_BITS-1:0]   resp_paddr,
    output logic [1:0]           resp_fault
);
    logic [VA_BITS-1:0] vaddr_q;
    logic [PA_BITS-1:0] base_q;
    access_t            acc_q;
    logic [PA_BITS-1:0] paddr_q;
    ptw_fault_e         fault_q;

    logic               req_take;
    logic               pte_take;
    logic [PG_BITS-1:0] offset;
    logic [PA_BITS-1:0] chk_paddr;
    ptw_fault_e         chk_fault;

    ptw_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_take      (req_take),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_resp_valid(mem_resp_valid),
        .pte_take      (pte_take),
        .resp_valid    (resp_valid)
    );

    ptw_addr_gen #(
        .VA_BITS(VA_BITS),
        .PA_BITS(PA_BITS),
        .PG_BITS(PG_BITS)
    ) u_addr (
        .base      (base_q),
        .vaddr     (vaddr_q),
        .entry_addr(mem_req_addr),
        .offset    (offset)
    );

    ptw_perm_check #(
        .PA_BITS  (PA_BITS),
        .PG_BITS  (PG_BITS),
        .WORD_BITS(WORD_BITS)
    ) u_perm (
        .entry (mem_resp_data),
        .acc   (acc_q),
        .offset(offset),
        .fault (chk_fault),
        .paddr (chk_paddr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vaddr_q <= '0;
            base_q  <= '0;
            acc_q   <= '0;
            paddr_q <= '0;
            fault_q <= FLT_NONE;
        end else begin
            if (req_take) begin
                vaddr_q        <= req_vaddr;
                base_q         <= ptbr;
                acc_q.is_write <= req_write;
                acc_q.is_super <= req_super;
            end
            if (pte_take) begin
                paddr_q <= chk_paddr;
                fault_q <= chk_fault;
            end
        end
    end

    assign resp_paddr = paddr_q;
    assign resp_fault = fault_q;

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr)); // R4

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault != 2'b00) |-> (resp_paddr == '0)); // R6

    AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_fault != 2'b11)); // R10

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault == 2'b00) |-> (resp_paddr[PG_BITS-1:0] == vaddr_q[PG_BITS-1:0])); // R10
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    localparam int VA = 32;
    localparam int PA = 32;
    localparam int PG = 12;
    localparam int WB = 32;
    localparam int PPN_W = PA - PG;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [VA-1:0] req_vaddr = '0;
    logic          req_write = 1'b0;
    logic          req_super = 1'b0;
    logic [PA-1:0] ptbr = '0;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [PA-1:0] mem_req_addr;
    logic          mem_resp_valid = 1'b0;
    logic [WB-1:0] mem_resp_data = '0;
    logic          resp_valid;
    logic [PA-1:0] resp_paddr;
    logic [1:0]    resp_fault;

    always #2.5 clk = ~clk;

    pt_walker #(.VA_BITS(VA), .PA_BITS(PA), .PG_BITS(PG), .WORD_BITS(WB)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_super(req_super), .ptbr(ptbr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_resp_valid(mem_resp_valid),
        .mem_resp_data(mem_resp_data), .resp_valid(resp_valid),
        .resp_paddr(resp_paddr), .resp_fault(resp_fault)
    );

    typedef struct {
        logic [PA-1:0] paddr;
        logic [1:0]    fault;
        string         tag;
    } exp_t;

    typedef struct {
        logic [PA-1:0] addr;
        logic [WB-1:0] pte;
    } rd_t;

    exp_t eq[$];
    rd_t  mq[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   ready_dly = 0;
    int   resp_dly = 0;
    bit   done = 1'b0;

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [WB-1:0] mk_pte(bit v, bit s, bit w, bit r, logic [PPN_W-1:0] ppn);
        logic [WB-1:0] e;
        e = '0;
        e[PPN_W-1:0] = ppn;
        e[PPN_W]   = r;
        e[PPN_W+1] = w;
        e[PPN_W+2] = s;
        e[PPN_W+3] = v;
        return e;
    endfunction

    // Memory model: accepts after ready_dly cycles, answers after resp_dly more
    initial begin
        wait (!rst);
        forever begin
            rd_t rd;
            @(negedge clk);
            if (mem_req_valid !== 1'b1) continue;
            if (mq.size() == 0) begin
                check(1'b0, "R2 unexpected memory read", 64'(mem_req_addr), 64'hX);
                rd.addr = mem_req_addr;
                rd.pte  = '0;
            end else begin
                rd = mq.pop_front();
                check(mem_req_addr == rd.addr, "R3 entry address", 64'(mem_req_addr), 64'(rd.addr));
            end
            for (int i = 0; i < ready_dly; i++) begin
                @(negedge clk);
                check(mem_req_valid === 1'b1 && mem_req_addr == rd.addr, "R4 request held",
                      64'({mem_req_valid, mem_req_addr}), 64'({1'b1, rd.addr}));
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            check(mem_req_valid === 1'b0, "R4 single read", 64'(mem_req_valid), 64'd0);
            for (int i = 0; i < resp_dly; i++) @(negedge clk);
            mem_resp_data  = rd.pte;
            mem_resp_valid = 1'b1;
            @(negedge clk);
            mem_resp_valid = 1'b0;
            mem_resp_data  = '0;
        end
    end

    // Monitor: compares responses with the scoreboard
    initial begin
        bit prev_rv;
        prev_rv = 1'b0;
        wait (!rst);
        forever begin
            @(negedge clk);
            if (prev_rv)
                check(resp_valid === 1'b0 && req_ready === 1'b1, "R11 single-cycle response",
                      64'({resp_valid, req_ready}), 64'b01);
            if (resp_valid === 1'b1) begin
                if (eq.size() == 0) begin
                    check(1'b0, "R2 unexpected response", 64'(resp_paddr), 64'hX);
                end else begin
                    exp_t e;
                    e = eq.pop_front();
                    check(resp_fault == e.fault, {e.tag, " fault code"}, 64'(resp_fault), 64'(e.fault));
                    check(resp_paddr == e.paddr, {e.tag, " physical address"}, 64'(resp_paddr), 64'(e.paddr));
                end
            end
            prev_rv = (resp_valid === 1'b1);
        end
    end

    task automatic walk(logic [VA-1:0] va, bit wr, bit sup, logic [PA-1:0] base,
                        logic [WB-1:0] pte, int rd_lat, int rs_lat, bit poke, string tag);
        exp_t          e;
        rd_t           r;
        logic [PA-1:0] ea;
        bit            v, s, w, rr;
        v  = pte[PPN_W+3];
        s  = pte[PPN_W+2];
        w  = pte[PPN_W+1];
        rr = pte[PPN_W];
        if (!v)                          e.fault = 2'b01;
        else if ((wr && !w) || (!wr && !rr) || (!sup && s)) e.fault = 2'b10;
        else                             e.fault = 2'b00;
        e.paddr = (e.fault == 2'b00) ? {pte[PPN_W-1:0], va[PG-1:0]} : '0;
        e.tag   = tag;
        ea      = base + (PA'(va[VA-1:PG]) << 2);
        r.addr  = ea;
        r.pte   = pte;
        while (req_ready !== 1'b1) @(negedge clk);
        ready_dly = rd_lat;
        resp_dly  = rs_lat;
        eq.push_back(e);
        mq.push_back(r);
        req_vaddr = va;
        req_write = wr;
        req_super = sup;
        ptbr      = base;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready === 1'b0, "R2 busy after accept", 64'(req_ready), 64'd0);
        if (poke) begin
            req_valid = 1'b1;
            req_vaddr = ~va;
            ptbr      = ~base;
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                check(req_ready === 1'b0, "R2 request ignored while busy", 64'(req_ready), 64'd0);
            end
            req_valid = 1'b0;
        end
        while (eq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        check(req_ready === 1'b1 && mem_req_valid === 1'b0 && resp_valid === 1'b0, "R1 during reset",
              64'({req_ready, mem_req_valid, resp_valid}), 64'b100);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready === 1'b1 && mem_req_valid === 1'b0 && resp_valid === 1'b0, "R1 after reset",
              64'({req_ready, mem_req_valid, resp_valid}), 64'b100);

        walk(32'h0000_5ABC, 0, 0, 32'h0010_0000, mk_pte(1,0,1,1,20'h12345), 1, 2, 0, "R10 user read");
        walk(32'h0000_7010, 1, 0, 32'h0010_0000, mk_pte(1,0,0,1,20'h00ABC), 0, 0, 0, "R7 write denied");
        walk(32'h0003_3FFF, 1, 1, 32'h0020_0000, mk_pte(1,1,1,0,20'hFEDCB), 2, 1, 0, "R10 write allowed");
        walk(32'h0004_0001, 0, 1, 32'h0020_0000, mk_pte(0,1,0,0,20'h11111), 0, 3, 0, "R6 not present");
        walk(32'h0004_0001, 1, 0, 32'h0020_0000, mk_pte(0,0,1,1,20'h22222), 1, 0, 0, "R6 priority");
        walk(32'h0008_8888, 0, 0, 32'h0030_0000, mk_pte(1,1,1,1,20'h33333), 0, 1, 0, "R8 user on sup page");
        walk(32'h0008_8888, 0, 1, 32'h0030_0000, mk_pte(1,1,1,1,20'h33333), 1, 1, 0, "R8 supervisor allowed");
        walk(32'h0009_0ABC, 0, 1, 32'h0030_0000, mk_pte(1,0,1,0,20'h44444), 0, 0, 0, "R9 read denied");
        walk(32'hFFFF_F123, 0, 0, 32'hFFFF_FFF0, mk_pte(1,0,0,1,20'h55555), 1, 1, 0, "R3 address wrap");
        walk(32'h0001_2345, 0, 0, 32'h0040_0000, mk_pte(1,0,0,1,20'h0A0A0), 2, 4, 1, "R2 busy poke");
        walk(32'h0002_0FFF, 1, 0, 32'h0040_0000, mk_pte(1,0,1,1,20'h00001), 20, 30, 0, "R5 long latency");
        walk(32'h0002_1000, 0, 0, 32'h0040_0000, mk_pte(1,0,1,1,20'hFFFFF), 0, 0, 0, "R5 zero latency");

        begin
            logic [31:0] lcg;
            lcg = 32'h1357_9BDF;
            for (int k = 0; k < 24; k++) begin
                logic [VA-1:0] va;
                logic [PA-1:0] b;
                logic [WB-1:0] p;
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                va  = lcg;
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                b   = {lcg[31:2], 2'b00};
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                p   = mk_pte(lcg[31], lcg[30], lcg[29], lcg[28], lcg[19:0]);
                walk(va, lcg[27], lcg[26], b, p, int'(lcg[25:24]), int'(lcg[23:21]), 0, "R10 mixed vector");
            end
        end

        repeat (4) @(negedge clk);
        check(eq.size() == 0 && mq.size() == 0, "R11 all answered", 64'(eq.size()), 64'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R5 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule